// File: doc/BRIEF.md
# Write-path check-bit error injector

This unit sits on one memory channel's write datapath. It deliberately corrupts the check bits of selected writes so that the error-detection and error-correction logic further down the path can be exercised. Software programs three registers through a plain register write/read port:

- an address-match pattern that holds the dimm, rank, bank, page and column values, plus one don't-care flag per field;
- a flip mask that is XORed into the check bits of a matching write;
- a control word that arms the unit and chooses the behaviour.

Each beat on the write path carries the decoded DRAM address fields, a flag that says which 32-byte half of the cache line the beat belongs to, and the computed check bits. One cycle later the unit presents the beat's check bits, corrupted when the beat was a hit, together with a one-cycle address-parity-error flag. Two status outputs show whether the unit is armed and how many hits it has served since it was last armed.

In one-shot mode the unit corrupts a single write and then disarms itself. In repeat mode it corrupts every matching write until software clears the control word. Flipping bits inside one aligned 16-bit symbol pair produces a correctable error downstream; flipping bits in both pairs produces an uncorrectable one.

Top module: `mem_err_inject`

## Requirements
- R1: After reset the unit is disarmed and the injection count reads 0. The match register reads 64'h0000_03E0_0000_0000 (all five don't-care flags set), the flip mask reads 0 and the control register reads 0.
- R2: out_valid equals wr_valid delayed by exactly one clock. out_check equals the previous cycle's wr_check whenever that beat was not a hit.
- R3: A hit requires all of the following: the unit is armed, wr_valid=1, wr_is_write=1, and every field whose don't-care flag is clear equals its match value. The match positions are column [13:0], page [29:14], bank [33:30], rank [35:34] and dimm bit 36. A read beat (wr_is_write=0) is never a hit.
- R4: Match bits 37, 38, 39, 40 and 41 are the don't-care flags for column, page, bank, rank and dimm, in that order. A set flag removes its field from the comparison.
- R5: Control bits [2:1] select the half. 00 matches either half, 01 only the lower half (wr_upper=0), 10 only the upper half (wr_upper=1), and 11 either half.
- R6: On a hit with control bit 3 set, out_check is wr_check XOR the flip mask. With control bit 3 clear, the check bits pass through unchanged even on a hit.
- R7: out_par_err is 1 for exactly the output cycle of a hit, and only when control bit 4 is set.
- R8: With control bit 0 (repeat) clear, the first hit after arming is corrupted and the unit disarms itself. Later matching writes pass unchanged.
- R9: With control bit 0 set, every hit is corrupted until the control register is written with 0.
- R10: Writing the match register (address 0) or the flip mask (address 1) stores the value and disarms the unit. Writing 0 to the control register (address 2) disarms it. Reads at address 2 return the control value in bits [4:0].
- R11: Writing a nonzero value to the control register arms the unit and resets the injection count to 0. Each hit then adds 1 to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 match, 1 flip mask, 2 control |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Readback of the selected register (combinational) |
| wr_valid | input | 1 | Beat present on the write path |
| wr_is_write | input | 1 | 1 for a write beat, 0 for a read beat |
| wr_dimm | input | 1 | Decoded dimm index |
| wr_rank | input | 2 | Decoded rank |
| wr_bank | input | 4 | Decoded bank |
| wr_page | input | 16 | Decoded page (row) |
| wr_col | input | 14 | Decoded column |
| wr_upper | input | 1 | 1 when the beat is the upper 32-byte half |
| wr_check | input | CHK_W | Computed check bits |
| out_valid | output | 1 | Registered beat valid |
| out_check | output | CHK_W | Registered, possibly corrupted check bits |
| out_par_err | output | 1 | Address-parity-error request for this beat |
| armed | output | 1 | Unit armed |
| inj_count | output | CNT_W | Hits served since the unit was last armed |

## Verification
A corrupted match register, control register or armed flag shows up at the ports on the first matching beat after the fault. The beat's check bits and parity flag differ from the expected values one cycle after the beat enters. The same fault also appears at once on armed, or on the register readback. A bad count shows on inj_count in the cycle after the hit that should have moved it. For this reason the bench compares every output against a behavioural model on every clock. The directed stimuli aim at the cases that differ only in one bit: each don't-care flag alone, each half selection against both halves, read beats against the same address, and the cycle after a one-shot hit.

// File: rtl/mem_err_inject.sv
module mem_err_inject #(
  parameter int CHK_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [63:0]      cfg_wdata,
  output logic [63:0]      cfg_rdata,
  input  logic             wr_valid,
  input  logic             wr_is_write,
  input  logic             wr_dimm,
  input  logic [1:0]       wr_rank,
  input  logic [3:0]       wr_bank,
  input  logic [15:0]      wr_page,
  input  logic [13:0]      wr_col,
  input  logic             wr_upper,
  input  logic [CHK_W-1:0] wr_check,
  output logic             out_valid,
  output logic [CHK_W-1:0] out_check,
  output logic             out_par_err,
  output logic             armed,
  output logic [CNT_W-1:0] inj_count
);
  localparam logic [1:0]  A_MATCH   = 2'd0;
  localparam logic [1:0]  A_FLIP    = 2'd1;
  localparam logic [1:0]  A_CTRL    = 2'd2;
  localparam logic [63:0] MATCH_RST = 64'h0000_03E0_0000_0000;

  logic [63:0]      match_q;
  logic [CHK_W-1:0] flip_q;
  logic [4:0]       ctl_q;
  logic [4:0]       fld_eq, fld_ok;
  logic             half_ok, hit;

  // field order LSB..MSB: column, page, bank, rank, dimm (matches flags 37..41)
  assign fld_eq = {wr_dimm == match_q[36], wr_rank == match_q[35:34],
                   wr_bank == match_q[33:30], wr_page == match_q[29:14],
                   wr_col == match_q[13:0]};
  assign fld_ok  = fld_eq | match_q[41:37];
  assign half_ok = (ctl_q[2:1] == 2'b00) | (ctl_q[1] & ~wr_upper) | (ctl_q[2] & wr_upper);
  assign hit     = armed & wr_valid & wr_is_write & (&fld_ok) & half_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q   <= MATCH_RST;
      flip_q    <= '0;
      ctl_q     <= '0;
      armed     <= 1'b0;
      inj_count <= '0;
    end else begin
      if (hit) begin
        inj_count <= inj_count + 1'b1;
        if (!ctl_q[0]) armed <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          A_MATCH: begin match_q <= cfg_wdata; armed <= 1'b0; end
          A_FLIP:  begin flip_q <= cfg_wdata[CHK_W-1:0]; armed <= 1'b0; end
          A_CTRL: begin
            ctl_q <= cfg_wdata[4:0];
            armed <= |cfg_wdata[4:0];
            if (|cfg_wdata[4:0]) inj_count <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_check   <= '0;
      out_par_err <= 1'b0;
    end else begin
      out_valid   <= wr_valid;
      out_check   <= wr_check ^ ({CHK_W{hit & ctl_q[3]}} & flip_q);
      out_par_err <= hit & ctl_q[4];
    end
  end

  always_comb begin
    case (cfg_addr)
      A_MATCH: cfg_rdata = match_q;
      A_FLIP:  cfg_rdata = 64'(flip_q);
      A_CTRL:  cfg_rdata = {59'd0, ctl_q};
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mem_err_inject_chk.sv
module mem_err_inject_chk #(
  parameter int CHK_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [4:0]       ctl_wr,
  input logic             wr_valid,
  input logic             wr_is_write,
  input logic [CHK_W-1:0] wr_check,
  input logic             out_valid,
  input logic [CHK_W-1:0] out_check,
  input logic             out_par_err,
  input logic             armed,
  input logic [CNT_W-1:0] inj_count,
  input logic [4:0]       ctl_q
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !out_valid);
  p_read_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_is_write) |=> (out_check == $past(wr_check)) && !out_par_err);
  p_idle_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (out_check == $past(wr_check)) && !out_par_err);
  p_no_ecc_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[3] |=> out_check == $past(wr_check));
  p_par_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_par_err |-> out_valid);
  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ctl_q[0] && !cfg_we) |=> (!armed || inj_count == $past(inj_count)));
  p_disarm_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == 2'd0 || cfg_addr == 2'd1)) |=> !armed);
  p_arm_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2 && ctl_wr != 5'd0) |=> (armed && inj_count == '0));
  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (inj_count == $past(inj_count) || inj_count == CNT_W'($past(inj_count) + 1'b1)));
endmodule

bind mem_err_inject mem_err_inject_chk #(.CHK_W(CHK_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .ctl_wr(cfg_wdata[4:0]),
  .wr_valid(wr_valid), .wr_is_write(wr_is_write), .wr_check(wr_check),
  .out_valid(out_valid), .out_check(out_check), .out_par_err(out_par_err),
  .armed(armed), .inj_count(inj_count), .ctl_q(ctl_q)
);

// File: tb/mem_err_inject_tb_top.sv
module mem_err_inject_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, wr_valid, wr_is_write, wr_dimm, wr_upper;
  logic [1:0]  cfg_addr, wr_rank;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic [3:0]  wr_bank;
  logic [15:0] wr_page;
  logic [13:0] wr_col;
  logic [31:0] wr_check, out_check;
  logic        out_valid, out_par_err, armed;
  logic [15:0] inj_count;

  mem_err_inject dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_valid(wr_valid), .wr_is_write(wr_is_write), .wr_dimm(wr_dimm),
    .wr_rank(wr_rank), .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
    .wr_upper(wr_upper), .wr_check(wr_check), .out_valid(out_valid), .out_check(out_check),
    .out_par_err(out_par_err), .armed(armed), .inj_count(inj_count));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [63:0] m_match;
  logic [31:0] m_mask, e_check;
  logic [4:0]  m_ctl;
  bit          m_armed, e_valid, e_par;
  int          m_count;

  localparam logic        BD = 1'b1;
  localparam logic [1:0]  BR = 2'd2;
  localparam logic [3:0]  BB = 4'd5;
  localparam logic [15:0] BP = 16'h1234;
  localparam logic [13:0] BC = 14'h0ABC;
  localparam logic [63:0] BASE = {27'd0, BD, BR, BB, BP, BC};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit fok, hok, hit;
    if (!rst_n) begin
      m_match = 64'h0000_03E0_0000_0000; m_mask = 0; m_ctl = 0; m_armed = 0; m_count = 0;
      e_valid = 0; e_check = 0; e_par = 0;
      return;
    end
    fok = (m_match[37] || wr_col == m_match[13:0]) && (m_match[38] || wr_page == m_match[29:14]) &&
          (m_match[39] || wr_bank == m_match[33:30]) && (m_match[40] || wr_rank == m_match[35:34]) &&
          (m_match[41] || wr_dimm == m_match[36]);
    case (m_ctl[2:1])
      2'b01:   hok = !wr_upper;
      2'b10:   hok = wr_upper;
      default: hok = 1'b1;
    endcase
    hit = m_armed && wr_valid && wr_is_write && fok && hok;
    e_valid = wr_valid;
    e_check = (hit && m_ctl[3]) ? (wr_check ^ m_mask) : wr_check;
    e_par   = hit && m_ctl[4];
    if (hit) begin
      m_count++;
      if (!m_ctl[0]) m_armed = 0;
    end
    if (cfg_we) begin
      if (cfg_addr == 0) begin m_match = cfg_wdata; m_armed = 0; end
      else if (cfg_addr == 1) begin m_mask = cfg_wdata[31:0]; m_armed = 0; end
      else if (cfg_addr == 2) begin
        m_ctl = cfg_wdata[4:0];
        m_armed = (m_ctl != 0);
        if (m_ctl != 0) m_count = 0;
      end
    end
  endtask

  task automatic compare();
    logic [63:0] rd;
    rd = (cfg_addr == 0) ? m_match : (cfg_addr == 1) ? {32'd0, m_mask} :
         (cfg_addr == 2) ? {59'd0, m_ctl} : 64'd0;
    chk(out_valid == e_valid, "R2 out_valid", 64'(out_valid), 64'(e_valid));
    chk(out_check == e_check, "R6 out_check", 64'(out_check), 64'(e_check));
    chk(out_par_err == e_par, "R7 out_par_err", 64'(out_par_err), 64'(e_par));
    chk(armed == m_armed, "R8 armed", 64'(armed), 64'(m_armed));
    chk(inj_count == 16'(m_count), "R11 inj_count", 64'(inj_count), 64'(m_count));
    chk(cfg_rdata == rd, "R10 cfg_rdata", cfg_rdata, rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [63:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0; cfg_addr = 2'd2;
  endtask

  // beat on base address with field k perturbed (k=5: none)
  task automatic beat(input int k, input logic up, input logic [31:0] c, input logic wrt);
    wr_valid = 1; wr_is_write = wrt; wr_upper = up; wr_check = c;
    wr_dimm = BD ^ (k == 4);
    wr_rank = BR ^ ((k == 3) ? 2'd3 : 2'd0);
    wr_bank = BB ^ ((k == 2) ? 4'hF : 4'h0);
    wr_page = BP ^ ((k == 1) ? 16'hFFFF : 16'h0);
    wr_col  = BC ^ ((k == 0) ? 14'h3FFF : 14'h0);
    tick();
    wr_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; wr_valid = 0; wr_is_write = 0;
    wr_dimm = 0; wr_rank = 0; wr_bank = 0; wr_page = 0; wr_col = 0; wr_upper = 0; wr_check = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(cfg_rdata == 64'h0000_03E0_0000_0000, "R1 match reset", cfg_rdata, 64'h0000_03E0_0000_0000);
    chk(!armed && inj_count == 0, "R1 armed/count reset", 64'(armed), 64'd0);

    // R2 pass-through while disarmed
    beat(5, 0, 32'hCAFE_0001, 1);
    chk(out_check == 32'hCAFE_0001 && out_valid, "R2 pass-through", 64'(out_check), 64'hCAFE_0001);

    // R3/R6/R8 one-shot, ECC only, full line
    cfg_wr(0, BASE);
    cfg_wr(1, 64'h0000_0003);
    cfg_wr(2, 64'h0E);
    beat(5, 0, 32'h1111_0000, 0);
    chk(out_check == 32'h1111_0000 && armed, "R3 read never hits", 64'(out_check), 64'h1111_0000);
    beat(2, 0, 32'h2222_0000, 1);
    chk(out_check == 32'h2222_0000, "R3 bank mismatch passes", 64'(out_check), 64'h2222_0000);
    beat(5, 1, 32'h3333_0000, 1);
    chk(out_check == 32'h3333_0003, "R6 flip on hit", 64'(out_check), 64'h3333_0003);
    chk(!armed && inj_count == 1, "R8 one-shot disarms", 64'(armed), 64'd0);
    beat(5, 1, 32'h4444_0000, 1);
    chk(out_check == 32'h4444_0000, "R8 second write clean", 64'(out_check), 64'h4444_0000);

    // R7/R9/R11 repeat with parity
    cfg_wr(2, 64'h1F);
    chk(armed && inj_count == 0, "R11 arm clears count", 64'(inj_count), 64'd0);
    beat(5, 0, 32'h5, 1);
    chk(out_check == 32'h6 && out_par_err, "R7 parity on hit", 64'(out_par_err), 64'd1);
    @(negedge clk);
    chk(!out_par_err, "R7 parity one cycle", 64'(out_par_err), 64'd0);
    beat(5, 1, 32'h5, 1);
    chk(out_check == 32'h6 && inj_count == 2, "R9 repeat keeps corrupting", 64'(inj_count), 64'd2);
    cfg_wr(2, 64'h0);
    chk(!armed, "R10 zero control disarms", 64'(armed), 64'd0);
    beat(5, 0, 32'h5, 1);
    chk(out_check == 32'h5, "R9 stops after clear", 64'(out_check), 64'h5);

    // R5 half selection
    cfg_wr(2, 64'h0B);
    beat(5, 1, 32'h10, 1);
    chk(out_check == 32'h10, "R5 lower-only ignores upper", 64'(out_check), 64'h10);
    beat(5, 0, 32'h10, 1);
    chk(out_check == 32'h13, "R5 lower-only hits lower", 64'(out_check), 64'h13);
    cfg_wr(2, 64'h0D);
    beat(5, 0, 32'h10, 1);
    chk(out_check == 32'h10, "R5 upper-only ignores lower", 64'(out_check), 64'h10);
    beat(5, 1, 32'h10, 1);
    chk(out_check == 32'h13, "R5 upper-only hits upper", 64'(out_check), 64'h13);
    cfg_wr(2, 64'h09);
    beat(5, 0, 32'h10, 1);
    beat(5, 1, 32'h20, 1);
    chk(out_check == 32'h23 && inj_count == 2, "R5 no half masking", 64'(out_check), 64'h23);

    // R4 each don't-care flag
    for (int k = 0; k < 5; k++) begin
      cfg_wr(0, BASE | (64'd1 << (37 + k)));
      cfg_wr(2, 64'h09);
      beat(k, 0, 32'h100, 1);
      chk(out_check == 32'h103, $sformatf("R4 flag %0d ignores field", k), 64'(out_check), 64'h103);
      beat((k + 1) % 5, 0, 32'h100, 1);
      chk(out_check == 32'h100, $sformatf("R4 flag %0d others still compared", k), 64'(out_check), 64'h100);
    end

    // R10 register write while armed disarms
    cfg_wr(0, BASE);
    cfg_wr(2, 64'h09);
    cfg_wr(1, 64'hF000_0000);
    chk(!armed, "R10 mask write disarms", 64'(armed), 64'd0);
    cfg_addr = 1; #1;
    chk(cfg_rdata == 64'hF000_0000, "R10 mask stored", cfg_rdata, 64'hF000_0000);
    beat(5, 0, 32'h1, 1);
    chk(out_check == 32'h1, "R10 no hit after disarm", 64'(out_check), 64'h1);
    cfg_wr(2, 64'h09);
    cfg_wr(0, BASE);
    chk(!armed, "R10 match write disarms", 64'(armed), 64'd0);

    // R6 ECC bit clear: parity only, check bits untouched
    cfg_wr(2, 64'h11);
    beat(5, 0, 32'h77, 1);
    chk(out_check == 32'h77 && out_par_err, "R6 no flip without ECC bit", 64'(out_check), 64'h77);
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule